// File: doc/BRIEF.md
# Dual-Sampled Edge Counting Prescaler

This block turns count events into single-cycle increment strobes for a 16-bit timer. Two event sources are available. The internal source gives one event per machine cycle, which is six system clocks. The external source looks at a count pin twice per machine cycle and takes a low sample followed by a high sample as a rising edge. The selected events then pass through a divider whose factor is 1, 2, 4 or 8.

A machine cycle is modelled as six state phases, counted 0 to 5 on the system clock. Phase 0 is the first cycle after reset. The count pin is sampled in phases 1 and 4. An edge seen in the phase-1 sample counts in the next machine cycle. An edge seen in the phase-4 sample counts one machine cycle after that.

The divider count is wiped, and any queued external event is dropped, in any of these cases: the source or divide select changes, the timer is switched off, the chip is idle, or the timer's reset logic raises a clear. The wipe takes effect at the clock edge that ends the cycle in which the condition is present.

Top module: `evt_prescaler`

## Requirements
- R1: While rst_n is low, inc_stb is 0, and the phase counter starts at phase 0 once rst_n is high.
- R2: With src_ext=0 and div_sel=0, inc_stb pulses once every 6 clocks, one pulse per machine cycle.
- R3: div_sel values 0, 1, 2 and 3 give division factors 1, 2, 4 and 8. With src_ext=0, consecutive strobes are 6, 12, 24 and 48 clocks apart.
- R4: inc_stb is never high for two clocks in a row.
- R5: With src_ext=1, an event is a low sample followed by a high sample, with samples taken only in phases 1 and 4. A pin pulse that falls between the two sample phases gives no strobe. A pin held high gives exactly one strobe.
- R6: With div_sel=0, a pin rise that is seen in the phase-1 sample gives a strobe during phase 1 of the next machine cycle, 7 clocks after the pin rises in phase 0. A rise first seen in the phase-4 sample gives a strobe one machine cycle later, 11 clocks after the pin rises in phase 2.
- R7: The external path counts at most one event per machine cycle. A pin that toggles every clock gives strobes exactly 6 clocks apart when div_sel=0.
- R8: A change of div_sel or src_ext clears the divider count. With div_sel=3, a change made 12 clocks after a strobe moves the next strobe to 36 clocks after that strobe for a new factor of 4, or to 60 clocks for a source flip there and back.
- R9: A one-cycle clr_req, raised 12 clocks after a strobe with div_sel=3, clears the divider count, so the next strobe comes 60 clocks after the earlier one.
- R10: While idle=1 no strobe is produced and the divider count is held at zero. Counting resumes when idle falls.
- R11: While timer_off=1 no strobe is produced. Counting resumes when timer_off falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ext | input | 1 | 0 selects the internal machine-cycle tick, 1 selects the edges on the count pin |
| div_sel | input | SEL_W | Division select; a code of k divides by 2^k |
| timer_off | input | 1 | Stops counting and clears the divider |
| idle | input | 1 | Holds the divider cleared while high |
| clr_req | input | 1 | Clear request from the timer's reset logic |
| cnt_pin | input | 1 | External count pin, already synchronised |
| inc_stb | output | 1 | One-clock timer increment strobe |

## Verification
The assertions check on every cycle that properties hold which do not depend on the stimulus. The phase counter steps 0 to 5 and wraps. Events leave the sampler only at the start of a machine cycle and never two in a row. A rising sample is queued in the slot its phase calls for. The divider count stays within the limit for the current factor and is zero after a configuration change. No strobe follows an idle or off cycle, and a strobe never lasts two clocks. Only the bench scenarios can show the things that need a whole stimulus: the exact distance between strobes for each factor, the 7- and 11-clock external latencies, narrow pulses being ignored, and how far a mid-period clear, idle or configuration change pushes the next strobe.

// File: rtl/evt_prescaler_pkg.sv
package evt_prescaler_pkg;

   typedef enum logic {
      SRC_TICK = 1'b0,
      SRC_PIN  = 1'b1
   } evt_src_e;

endpackage

// File: rtl/evt_phase_gen.sv
module evt_phase_gen #(
   parameter int PHASES = 6,
   parameter int SAMP_A = 1,
   parameter int SAMP_B = 4,
   localparam int PH_W = $clog2(PHASES)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] phase,
   output logic            at_first,
   output logic            at_samp_a,
   output logic            at_samp_b,
   output logic            at_last
);

   localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);
   localparam logic [PH_W-1:0] PH_A    = PH_W'(SAMP_A);
   localparam logic [PH_W-1:0] PH_B    = PH_W'(SAMP_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (phase == LAST_PH) begin
         phase <= '0;
      end else begin
         phase <= phase + PH_W'(1);
      end
   end

   assign at_first  = (phase == '0);
   assign at_samp_a = (phase == PH_A);
   assign at_samp_b = (phase == PH_B);
   assign at_last   = (phase == LAST_PH);

   // R2: the machine cycle is a strict 0..PHASES-1 sequence
   a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == LAST_PH) |=> (phase == '0));
   a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != LAST_PH) |=> (phase == $past(phase) + PH_W'(1)));
   a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= LAST_PH);

endmodule

// File: rtl/evt_edge_sampler.sv
module evt_edge_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic pin,
   input  logic at_samp_a,
   input  logic at_samp_b,
   input  logic at_last,
   output logic fire
);

   logic last_smp;
   logic due_next;
   logic due_later;
   logic rise;

   // a rise is a low sample followed by a high one
   assign rise = pin & ~last_smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_smp <= 1'b1;
      end else if (at_samp_a || at_samp_b) begin
         last_smp <= pin;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         due_next  <= 1'b0;
         due_later <= 1'b0;
         fire      <= 1'b0;
      end else if (flush) begin
         due_next  <= 1'b0;
         due_later <= 1'b0;
         fire      <= 1'b0;
      end else begin
         if (at_last) begin
            fire      <= due_next;
            due_next  <= due_later;
            due_later <= 1'b0;
         end else begin
            fire <= 1'b0;
            if (at_samp_a && rise) begin
               due_next <= 1'b1;
            end
            if (at_samp_b && rise) begin
               due_later <= 1'b1;
            end
         end
      end
   end

   // R6: the early sample queues for the next machine cycle
   a_r6_early_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (at_samp_a && rise && !flush) |=> due_next);
   // R6: the late sample queues one machine cycle further out
   a_r6_late_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (at_samp_b && rise && !flush) |=> due_later);
   // R5: events leave only at the start of a machine cycle
   a_r5_fire_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(at_last));
   // R7: never two events back to back
   a_r7_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

endmodule

// File: rtl/evt_div_stage.sv
module evt_div_stage
   import evt_prescaler_pkg::*;
#(
   parameter int SEL_W   = 2,
   parameter bit REG_OUT = 1'b1,
   localparam int CNT_W  = (1 << SEL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  evt_src_e         src,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             off,
   input  logic             idle,
   input  logic             clr,
   input  logic             ev_tick,
   input  logic             ev_pin,
   output logic             wipe,
   output logic             inc_stb
);

   evt_src_e         src_q;
   logic [SEL_W-1:0] div_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             cfg_chg;
   logic             ev;
   logic             wrap;

   assign lim     = CNT_W'((32'd1 << div_sel) - 32'd1);
   assign cfg_chg = (src != src_q) || (div_sel != div_q);
   assign wipe    = cfg_chg | off | idle | clr;
   assign ev      = (src == SRC_PIN) ? ev_pin : ev_tick;
   assign wrap    = ev & ~wipe & (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= SRC_TICK;
         div_q <= '0;
      end else begin
         src_q <= src;
         div_q <= div_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (wipe) begin
         cnt <= '0;
      end else if (ev) begin
         cnt <= (cnt == lim) ? '0 : cnt + CNT_W'(1);
      end
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic stb_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stb_r <= 1'b0;
            end else begin
               stb_r <= wrap;
            end
         end
         assign inc_stb = stb_r;

         // R10: idle leaves no strobe behind
         a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            idle |=> !inc_stb);
         // R9: a clear request leaves no strobe behind
         a_r9_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> !inc_stb);
      end else begin : g_comb_out
         assign inc_stb = wrap;
      end
   endgenerate

   // R8: a configuration change leaves the count at zero
   a_r8_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> (cnt == '0));
   // R3: the count never passes the limit of a stable factor
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_chg |-> (cnt <= lim));
   // R10: idle holds the count at zero
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> (cnt == '0));
   // R4: the strobe lasts one clock
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      inc_stb |=> !inc_stb);

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler
   import evt_prescaler_pkg::*;
#(
   parameter int PHASES  = 6,
   parameter int SAMP_A  = 1,
   parameter int SAMP_B  = 4,
   parameter int SEL_W   = 2,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_ext,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             timer_off,
   input  logic             idle,
   input  logic             clr_req,
   input  logic             cnt_pin,
   output logic             inc_stb
);

   localparam int PH_W = $clog2(PHASES);

   generate
      if (PHASES < 4) begin : g_bad_phases
         $error("PHASES must be at least 4");
      end
      if (SAMP_A < 0 || SAMP_A >= SAMP_B) begin : g_bad_order
         $error("SAMP_A must be non-negative and below SAMP_B");
      end
      if (SAMP_B >= PHASES - 1) begin : g_bad_late
         $error("SAMP_B must come before the last phase");
      end
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("SEL_W must lie in 1..4");
      end
   endgenerate

   logic [PH_W-1:0] phase;
   logic            at_first;
   logic            at_samp_a;
   logic            at_samp_b;
   logic            at_last;
   logic            pin_fire;
   logic            wipe;
   evt_src_e        src;

   assign src = src_ext ? SRC_PIN : SRC_TICK;

   evt_phase_gen #(
      .PHASES (PHASES),
      .SAMP_A (SAMP_A),
      .SAMP_B (SAMP_B)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .at_first  (at_first),
      .at_samp_a (at_samp_a),
      .at_samp_b (at_samp_b),
      .at_last   (at_last)
   );

   evt_edge_sampler u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (wipe),
      .pin       (cnt_pin),
      .at_samp_a (at_samp_a),
      .at_samp_b (at_samp_b),
      .at_last   (at_last),
      .fire      (pin_fire)
   );

   evt_div_stage #(
      .SEL_W   (SEL_W),
      .REG_OUT (REG_OUT)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src),
      .div_sel (div_sel),
      .off     (timer_off),
      .idle    (idle),
      .clr     (clr_req),
      .ev_tick (at_first),
      .ev_pin  (pin_fire),
      .wipe    (wipe),
      .inc_stb (inc_stb)
   );

   generate
      if (REG_OUT) begin : g_chk_reg
         // R11: switching off leaves no strobe behind
         a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            timer_off |=> !inc_stb);
         // R2: strobes land in phase 1 with a registered output
         a_r2_stb_phase: assert property (@(posedge clk) disable iff (!rst_n)
            inc_stb |-> (phase == PH_W'(1)));
      end
   endgenerate

   // R1: no strobe straight out of reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !inc_stb);

endmodule

// File: tb/sim_evt_prescaler.sv
module sim_evt_prescaler;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       src_ext = 1'b0;
   logic [1:0] div_sel = 2'd0;
   logic       timer_off = 1'b0;
   logic       idle = 1'b0;
   logic       clr_req = 1'b0;
   logic       pin_man = 1'b0;
   logic       pin_auto = 1'b0;
   logic [1:0] pmode = 2'd0;
   logic       cnt_pin;
   logic       inc_stb;

   int checks = 0;
   int errors = 0;
   int dbl = 0;
   int bph = 0;
   int tcnt = 0;
   bit prev_stb = 1'b0;
   bit done = 1'b0;

   assign cnt_pin = (pmode == 2'd0) ? pin_man : pin_auto;

   always #(CLK_PERIOD / 2) clk = ~clk;

   evt_prescaler u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_ext   (src_ext),
      .div_sel   (div_sel),
      .timer_off (timer_off),
      .idle      (idle),
      .clr_req   (clr_req),
      .cnt_pin   (cnt_pin),
      .inc_stb   (inc_stb)
   );

   // phase model from the requirements: 0 after reset, 0..5 repeating
   always @(posedge clk) begin
      if (!rst_n) bph <= 0;
      else        bph <= (bph == 5) ? 0 : bph + 1;
   end

   // automatic pin patterns: 1 toggles every clock, 2 every 6 clocks
   always @(negedge clk) begin
      if (pmode == 2'd1) begin
         pin_auto <= ~pin_auto;
      end else if (pmode == 2'd2) begin
         if (tcnt == 5) begin
            tcnt     <= 0;
            pin_auto <= ~pin_auto;
         end else begin
            tcnt <= tcnt + 1;
         end
      end
   end

   // R4 monitor
   always @(negedge clk) begin
      if (rst_n && inc_stb && prev_stb) dbl++;
      prev_stb <= inc_stb;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_stb(input int limit, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!inc_stb && n <= limit);
   endtask

   task automatic count_stb(input int cyc, output int n);
      n = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (inc_stb) n++;
      end
   endtask

   task automatic go_phase(input int p);
      do @(negedge clk); while (bph != p);
   endtask

   task automatic setup(input bit ext, input logic [1:0] d);
      @(negedge clk);
      src_ext = ext;
      div_sel = d;
      repeat (20) @(negedge clk);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(inc_stb == 1'b0, "R1 reset quiet", inc_stb, 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(bph == 1, "R1 phase start", bph, 1);
   endtask

   task automatic t_tick_div(input logic [1:0] d, input string req);
      int n;
      setup(1'b0, d);
      wait_stb(200, n);
      wait_stb(200, n);
      chk(n == (6 << d), req, n, 6 << d);
   endtask

   task automatic t_latency();
      int n;
      pmode   = 2'd0;
      pin_man = 1'b0;
      setup(1'b1, 2'd0);
      go_phase(0);
      pin_man = 1'b1;
      wait_stb(40, n);
      chk(n == 7, "R6 early sample latency", n, 7);
      pin_man = 1'b0;
      repeat (20) @(negedge clk);
      go_phase(2);
      pin_man = 1'b1;
      wait_stb(40, n);
      chk(n == 11, "R6 late sample latency", n, 11);
      pin_man = 1'b0;
   endtask

   task automatic t_pin_shapes();
      int n;
      pmode   = 2'd0;
      pin_man = 1'b0;
      setup(1'b1, 2'd0);
      // R5 narrow pulse between the sample phases
      for (int k = 0; k < 4; k++) begin
         go_phase(2);
         pin_man = 1'b1;
         @(negedge clk);
         pin_man = 1'b0;
      end
      count_stb(30, n);
      chk(n == 0, "R5 narrow pulse ignored", n, 0);
      // R5 steady high gives a single event
      pin_man = 1'b1;
      count_stb(60, n);
      chk(n == 1, "R5 held high counts once", n, 1);
      pin_man = 1'b0;
      // R5 slow square wave, one event per two machine cycles
      pmode = 2'd2;
      wait_stb(100, n);
      wait_stb(100, n);
      chk(n == 12, "R5 square wave div1", n, 12);
      setup(1'b1, 2'd1);
      wait_stb(100, n);
      wait_stb(100, n);
      chk(n == 24, "R5 square wave div2", n, 24);
      pmode = 2'd0;
   endtask

   task automatic t_fast_pin();
      int n;
      pmode = 2'd1;
      setup(1'b1, 2'd0);
      wait_stb(40, n);
      for (int k = 0; k < 3; k++) begin
         wait_stb(40, n);
         chk(n == 6, "R7 one event per machine cycle", n, 6);
      end
      pmode   = 2'd0;
      pin_man = 1'b0;
   endtask

   task automatic t_cfg_change();
      int n;
      setup(1'b0, 2'd3);
      wait_stb(100, n);
      repeat (12) @(negedge clk);
      div_sel = 2'd2;
      wait_stb(100, n);
      chk(n + 12 == 36, "R8 divide change clears", n + 12, 36);
      setup(1'b0, 2'd3);
      wait_stb(100, n);
      repeat (12) @(negedge clk);
      src_ext = 1'b1;
      @(negedge clk);
      src_ext = 1'b0;
      wait_stb(100, n);
      chk(n + 13 == 60, "R8 source change clears", n + 13, 60);
   endtask

   task automatic t_clear();
      int n;
      setup(1'b0, 2'd3);
      wait_stb(100, n);
      repeat (12) @(negedge clk);
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
      wait_stb(100, n);
      chk(n + 13 == 60, "R9 clear request", n + 13, 60);
   endtask

   task automatic t_idle();
      int n;
      setup(1'b0, 2'd0);
      idle = 1'b1;
      count_stb(60, n);
      chk(n == 0, "R10 idle no strobe", n, 0);
      idle = 1'b0;
      wait_stb(20, n);
      chk(n <= 8, "R10 resume after idle", n, 8);
      setup(1'b0, 2'd3);
      wait_stb(100, n);
      repeat (12) @(negedge clk);
      idle = 1'b1;
      @(negedge clk);
      idle = 1'b0;
      wait_stb(100, n);
      chk(n + 13 == 60, "R10 idle clears count", n + 13, 60);
   endtask

   task automatic t_off();
      int n;
      setup(1'b0, 2'd0);
      timer_off = 1'b1;
      count_stb(60, n);
      chk(n == 0, "R11 off no strobe", n, 0);
      timer_off = 1'b0;
      wait_stb(20, n);
      chk(n <= 8, "R11 resume after off", n, 8);
   endtask

   initial begin
      t_reset();
      t_tick_div(2'd0, "R2 tick div1");
      t_tick_div(2'd1, "R3 tick div2");
      t_tick_div(2'd2, "R3 tick div4");
      t_tick_div(2'd3, "R3 tick div8");
      t_latency();
      t_pin_shapes();
      t_fast_pin();
      t_cfg_change();
      t_clear();
      t_idle();
      t_off();
      chk(dbl == 0, "R4 single clock strobe", dbl, 0);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", WD_CYCLES, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule